// File: doc/BRIEF.md
# Dual-Slope Converter Phase Sequencer

This block is the digital control of a dual-slope integrating converter. It divides the oscillator clock down to a count pulse. It then steps through the three phases of every conversion, in a fixed order and without pause: integrate the input for a fixed time, de-integrate against a reference of opposite sign until the integrator returns to zero, and auto-zero. Each phase has its own analog switch select output, and only one select is active at a time. The analog parts (integrator, comparator and switches) sit outside the block. They report back through one comparator line, which is high while the integrator output is above zero.

Every conversion has the same total length. The de-integrate count is variable, so the auto-zero phase takes up the count pulses that de-integrate did not use. A status level is high while the input or the reference is applied and low during auto-zero. A host can use its falling edge as a handshake that a new result is ready. The result is a polarity bit, an 11-bit magnitude and an overrange flag. It is held in output registers and changes only once per conversion.

Top module: `dsq_sequencer`

## Requirements
- R1: While reset is high, and after it is released, the zero switch select is the only active select, busy is low and all result outputs are 0. The first integrate phase begins after 1000 count pulses (4000 clocks) of auto-zero.
- R2: One count pulse is 4 clocks. The integrate phase lasts exactly 1000 count pulses, and during it sw_input is the only active select.
- R3: At the last integrate count pulse the comparator is sampled into the polarity: 1 if cmp_above is high, 0 if low. During de-integrate, polarity 1 selects sw_ref_neg and polarity 0 selects sw_ref_pos. rd_positive shows this polarity once the conversion completes.
- R4: The result magnitude N is the number of de-integrate count pulses that complete before the count pulse at which cmp_above first differs from the polarity. De-integrate then lasts N+1 count pulses, and rd_magnitude shows N.
- R5: Each conversion cycle lasts exactly 4000 count pulses, so auto-zero lasts 2999-N count pulses after a result N.
- R6: If no crossing is seen by the 2000th de-integrate count pulse, de-integrate ends there. rd_overrange is then set, rd_magnitude is 1999, and auto-zero lasts exactly 1000 count pulses.
- R7: busy is high during integrate and de-integrate and low during auto-zero.
- R8: The result outputs change only on the clock edge that ends de-integrate. A normal conversion clears rd_overrange.
- R9: The phases run auto-zero, integrate, de-integrate and repeat, and exactly one of the four select outputs is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_above | input | 1 | Comparator: integrator output above zero |
| sw_input | output | 1 | Connect input signal to integrator |
| sw_ref_pos | output | 1 | Apply positive reference |
| sw_ref_neg | output | 1 | Apply negative reference |
| sw_zero | output | 1 | Auto-zero switch select |
| busy | output | 1 | Conversion status, low in auto-zero |
| rd_positive | output | 1 | Latched polarity of last result |
| rd_magnitude | output | 11 | Latched magnitude of last result |
| rd_overrange | output | 1 | Last conversion ran out of range |

## Verification
The assertions assume that cmp_above is synchronous to clk. It must be stable around each rising edge, and it may change only once the analog integrator has actually crossed zero. No input synchronizer is modelled, and the latency counts in the requirements depend on that. The bench models the integrator by driving cmp_above on falling edges only. It sets the sign of the input while integrate runs, then flips the comparator once, a set number of count pulses into de-integrate, or never, to force overrange. This keeps every stimulus consistent with a real integrator that crosses zero at most once per de-integrate phase.

// File: rtl/dsq_pkg.sv
package dsq_pkg;
  typedef enum logic [1:0] {
    PH_ZERO  = 2'd0,
    PH_INTEG = 2'd1,
    PH_DEINT = 2'd2
  } phase_e;
endpackage

// File: rtl/dsq_tick_gen.sv
module dsq_tick_gen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      assign tick = 1'b1;
    end else begin : g_div
      localparam int DIV_W = $clog2(CLK_DIV);
      logic [DIV_W-1:0] div_q;
      assign tick = (div_q == DIV_W'(CLK_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst)       div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
      end
      // R2: divider never runs past its terminal value
      p_div_range_r2: assert property (@(posedge clk) disable iff (rst)
        div_q <= DIV_W'(CLK_DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/dsq_phase_fsm.sv
module dsq_phase_fsm
  import dsq_pkg::*;
#(
  parameter int INT_CNT   = 1000,
  parameter int DEINT_MAX = 2000,
  parameter int CYCLE_CNT = 4000,
  localparam int CNT_W    = $clog2(CYCLE_CNT),
  localparam int MAG_W    = $clog2(DEINT_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             cmp_above,
  output phase_e           phase_q,
  output logic             pol_q,
  output logic             done,
  output logic             done_ovr,
  output logic [MAG_W-1:0] done_mag
);
  localparam int ZERO_START = INT_CNT + DEINT_MAX;

  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] deint_n;
  logic             last_cyc;
  logic             crossed;
  logic             at_limit;

  assign last_cyc = (cyc_q == CNT_W'(CYCLE_CNT - 1));
  assign deint_n  = cyc_q - CNT_W'(INT_CNT);
  assign crossed  = (cmp_above != pol_q);
  assign at_limit = (deint_n == CNT_W'(DEINT_MAX - 1));
  assign done     = tick && (phase_q == PH_DEINT) && (crossed || at_limit);
  assign done_ovr = !crossed;
  assign done_mag = deint_n[MAG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_ZERO;
      cyc_q   <= CNT_W'(ZERO_START);
      pol_q   <= 1'b0;
    end else if (tick) begin
      cyc_q <= last_cyc ? '0 : cyc_q + 1'b1;
      case (phase_q)
        PH_ZERO:  if (last_cyc) phase_q <= PH_INTEG;
        PH_INTEG: if (cyc_q == CNT_W'(INT_CNT - 1)) begin
                    phase_q <= PH_DEINT;
                    pol_q   <= cmp_above;
                  end
        PH_DEINT: if (crossed || at_limit) phase_q <= PH_ZERO;
        default:  phase_q <= PH_ZERO;
      endcase
    end
  end

  // R9: legal successor of each phase
  p_order_int_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INTEG) |=> (phase_q == PH_INTEG || phase_q == PH_DEINT));
  p_order_de_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DEINT) |=> (phase_q == PH_DEINT || phase_q == PH_ZERO));
  p_order_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_ZERO) |=> (phase_q == PH_ZERO || phase_q == PH_INTEG));
  // R2: integrate stays inside its fixed window
  p_int_window_r2: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_INTEG) |-> (cyc_q < CNT_W'(INT_CNT)));
  // R6: de-integrate never exceeds its limit
  p_deint_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DEINT) |-> (cyc_q >= CNT_W'(INT_CNT) && cyc_q < CNT_W'(ZERO_START)));
  // R3: polarity frozen through de-integrate
  p_pol_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_DEINT) |=> $stable(pol_q));
  // R5: cycle counter stays in range
  p_cyc_range_r5: assert property (@(posedge clk) disable iff (rst)
    cyc_q < CNT_W'(CYCLE_CNT));
endmodule

// File: rtl/dsq_result_reg.sv
module dsq_result_reg #(
  parameter int DEINT_MAX = 2000,
  localparam int MAG_W    = $clog2(DEINT_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             pol,
  input  logic             ovr,
  input  logic [MAG_W-1:0] mag,
  output logic             rd_positive,
  output logic             rd_overrange,
  output logic [MAG_W-1:0] rd_magnitude
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_positive  <= 1'b0;
      rd_overrange <= 1'b0;
      rd_magnitude <= '0;
    end else if (load) begin
      rd_positive  <= pol;
      rd_overrange <= ovr;
      rd_magnitude <= mag;
    end
  end

  // R6: an overrange result always carries the saturated magnitude
  p_ovr_mag_r6: assert property (@(posedge clk) disable iff (rst)
    rd_overrange |-> (rd_magnitude == MAG_W'(DEINT_MAX - 1)));
endmodule

// File: rtl/dsq_sequencer.sv
module dsq_sequencer
  import dsq_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int INT_CNT   = 1000,
  parameter int DEINT_MAX = 2000,
  parameter int CYCLE_CNT = 4000,
  localparam int MAG_W    = $clog2(DEINT_MAX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmp_above,
  output logic             sw_input,
  output logic             sw_ref_pos,
  output logic             sw_ref_neg,
  output logic             sw_zero,
  output logic             busy,
  output logic             rd_positive,
  output logic [MAG_W-1:0] rd_magnitude,
  output logic             rd_overrange
);
  logic             tick;
  phase_e           phase_q;
  logic             pol_q;
  logic             done;
  logic             done_ovr;
  logic [MAG_W-1:0] done_mag;

  dsq_tick_gen #(.CLK_DIV(CLK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .tick(tick)
  );

  dsq_phase_fsm #(
    .INT_CNT  (INT_CNT),
    .DEINT_MAX(DEINT_MAX),
    .CYCLE_CNT(CYCLE_CNT)
  ) u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .cmp_above(cmp_above),
    .phase_q  (phase_q),
    .pol_q    (pol_q),
    .done     (done),
    .done_ovr (done_ovr),
    .done_mag (done_mag)
  );

  dsq_result_reg #(.DEINT_MAX(DEINT_MAX)) u_res (
    .clk         (clk),
    .rst         (rst),
    .load        (done),
    .pol         (pol_q),
    .ovr         (done_ovr),
    .mag         (done_mag),
    .rd_positive (rd_positive),
    .rd_overrange(rd_overrange),
    .rd_magnitude(rd_magnitude)
  );

  assign sw_input   = (phase_q == PH_INTEG);
  assign sw_ref_pos = (phase_q == PH_DEINT) && !pol_q;
  assign sw_ref_neg = (phase_q == PH_DEINT) &&  pol_q;
  assign sw_zero    = (phase_q == PH_ZERO);
  assign busy       = (phase_q == PH_INTEG) || (phase_q == PH_DEINT);

  // R9: exactly one switch select at a time
  p_onehot_sw_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot({sw_input, sw_ref_pos, sw_ref_neg, sw_zero}));
  // R7: status low only in auto-zero
  p_busy_r7: assert property (@(posedge clk) disable iff (rst)
    busy == !sw_zero);
  // R8: results frozen outside de-integrate
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_DEINT) |=> ($stable(rd_magnitude) && $stable(rd_positive)
                               && $stable(rd_overrange)));
endmodule

// File: tb/dsq_sequencer_test.sv
module dsq_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_above = 1'b0;
  logic        sw_input, sw_ref_pos, sw_ref_neg, sw_zero, busy;
  logic        rd_positive, rd_overrange;
  logic [10:0] rd_magnitude;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  dsq_sequencer uut (
    .clk(clk), .rst(rst), .cmp_above(cmp_above),
    .sw_input(sw_input), .sw_ref_pos(sw_ref_pos), .sw_ref_neg(sw_ref_neg),
    .sw_zero(sw_zero), .busy(busy), .rd_positive(rd_positive),
    .rd_magnitude(rd_magnitude), .rd_overrange(rd_overrange)
  );

  // {sign, value}; value 2000 means the comparator never crosses
  localparam logic [12:0] VEC [6] = '{
    {1'b1, 12'd0}, {1'b0, 12'd1}, {1'b1, 12'd537},
    {1'b0, 12'd1234}, {1'b1, 12'd1999}, {1'b0, 12'd2000}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_reset_state();
    chk("R1 sw_zero", sw_zero, 1);
    chk("R1 other selects", {sw_input, sw_ref_pos, sw_ref_neg}, 0);
    chk("R1 busy", busy, 0);
    chk("R1 results", {rd_positive, rd_overrange, rd_magnitude}, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int cnt;
    int prev_mag = 0;
    int prev_pos = 0;
    int prev_ovr = 0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    // R1: initial auto-zero of 1000 count pulses
    cnt = 0;
    while (sw_zero) begin cnt++; @(negedge clk); end
    chk("R1 first auto-zero clocks", cnt, 4000);

    for (int i = 0; i < 6; i++) begin
      logic s;
      int v;
      logic over;
      s = VEC[i][12];
      v = int'(VEC[i][11:0]);
      over = (v == 2000);
      // integrate: present input sign on the comparator
      cmp_above = s;
      cnt = 0;
      while (sw_input) begin
        if (busy !== 1'b1) chk("R7 busy in integrate", busy, 1);
        cnt++; @(negedge clk);
      end
      chk("R2 integrate clocks", cnt, 4000);
      chk("R9 integrate followed by de-integrate", sw_ref_pos | sw_ref_neg, 1);
      chk("R3 reference select", {sw_ref_neg, sw_ref_pos}, s ? 2 : 1);
      chk("R7 busy in de-integrate", busy, 1);
      chk("R8 magnitude held", rd_magnitude, prev_mag);
      chk("R8 polarity held", rd_positive, prev_pos);
      chk("R8 overrange held", rd_overrange, prev_ovr);
      cnt = 0;
      while (sw_ref_pos | sw_ref_neg) begin
        if (!over && cnt == 4 * v) cmp_above = ~s;
        cnt++; @(negedge clk);
      end
      if (over) begin
        chk("R6 de-integrate clocks", cnt, 8000);
        chk("R6 overrange flag", rd_overrange, 1);
        chk("R6 saturated magnitude", rd_magnitude, 1999);
      end else begin
        chk("R4 de-integrate clocks", cnt, 4 * (v + 1));
        chk("R4 magnitude", rd_magnitude, v);
        chk("R8 overrange cleared", rd_overrange, 0);
      end
      chk("R3 latched polarity", rd_positive, s);
      chk("R7 busy low in auto-zero", busy, 0);
      cnt = 0;
      while (sw_zero) begin cnt++; @(negedge clk); end
      if (over) chk("R6 auto-zero clocks", cnt, 4000);
      else      chk("R5 auto-zero clocks", cnt, 4 * (2999 - v));
      prev_mag = int'(rd_magnitude);
      prev_pos = int'(rd_positive);
      prev_ovr = int'(rd_overrange);
    end

    // directed: reset in the middle of integrate
    chk("R9 next phase is integrate", sw_input, 1);
    repeat (37) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    cnt = 0;
    while (sw_zero) begin cnt++; @(negedge clk); end
    chk("R1 auto-zero after reset clocks", cnt, 4000);
    chk("R1 integrate follows", sw_input, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule